// File: doc/BRIEF.md
# Four-Phase Asynchronous Read Responder

This block is the memory side of a read-only bus on which a single requester and the responder share one bidirectional address/data path. The two sides run on unrelated clocks and agree on each step through level signals. These are a request line, an acknowledge line that both sides may drive, and a data-ready line. The responder samples the address that comes with a request and acknowledges it. It then waits for the request to be withdrawn, and in parallel counts out an access latency. When both are done it presents the word read from an internal lookup array and raises data-ready. The requester acknowledges the data, and the responder then releases the bus and clears data-ready. It waits for the acknowledge to clear before it serves the next request.

Every incoming handshake line passes through a two-stage synchronizer before the five-state controller acts on it. The shared bus and the shared acknowledge line are each modelled as a value plus an output enable. The surrounding logic builds the actual tri-state or wired connection.

Top module: `async_read_responder`

## Requirements
- R1: After reset the block is idle: `ack_o`, `drdy_o`, `bus_oe` and `bus_o` are 0, and `ack_oe` is 1.
- R2: From idle, `ack_o` rises on the third rising clock edge after `req_i` rises. Two of those edges are synchronizer stages.
- R3: The address on `bus_i` is captured when the request is accepted. Later changes on `bus_i` do not alter the returned word.
- R4: `ack_o` stays high while `req_i` is high, and falls on the third rising edge after `req_i` falls.
- R5: The access latency (LATENCY cycles) runs alongside the request-release exchange. If ack rose at edge A and fell at edge F, `drdy_o` rises at edge max(A+LATENCY+1, F+1).
- R6: While `drdy_o` is high, `bus_oe` is 1 and `bus_o` is stable and holds word(i), where i = address bits [7:0]. word(i) has upper byte i XOR 0xC3 and lower byte (i + 0x11) mod 256.
- R7: `drdy_o` and `bus_oe` fall on the third rising edge after `ack_i` rises. Whenever `bus_oe` is 0, `bus_o` is 0.
- R8: `ack_oe` is 0 from the rise of `drdy_o` until the block is idle again, so the responder never drives acknowledge during the requester's acknowledge phase. It is 1 again three edges after `ack_i` falls.
- R9: A request raised while `ack_i` is still high is not accepted. `ack_o` stays 0 and rises on the fourth rising edge after `ack_i` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock of the responder |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| req_i | input | 1 | Read request from the requester (asynchronous) |
| ack_i | input | 1 | Requester's drive of the shared acknowledge line (asynchronous) |
| bus_i | input | DATA_W | Shared bus as seen by the responder; carries the address |
| ack_o | output | 1 | Responder's value for the shared acknowledge line |
| ack_oe | output | 1 | Responder's enable on the shared acknowledge line |
| drdy_o | output | 1 | Read data is on the bus |
| bus_o | output | DATA_W | Read data toward the shared bus |
| bus_oe | output | 1 | Responder's enable on the shared bus |

## Verification
The bench acts as the requester. It varies how long it holds the request and how long it waits before acknowledging data, and it changes the bus right after the request drops. A responder that sampled the bus late would then return the word for the wrong address. A long request hold checks that data-ready waits for the acknowledge to be released, and a short hold checks that the latency overlaps the release. A design that added the two delays, or that ignored one of them, lands on the wrong edge. Addresses 0, 255, 256 and 0xFFFF check that only the low byte indexes the array. One request is raised while the previous acknowledge is still high. A controller that does not wait for acknowledge to clear would accept that request early and collide on the acknowledge line.

// File: rtl/arsp_pkg.sv
package arsp_pkg;

  typedef enum logic [2:0] {
    RS_IDLE,
    RS_ACK,
    RS_WAIT,
    RS_DATA,
    RS_DONE
  } rsp_state_e;

  // Content of the lookup array at a given index (low byte of the address).
  function automatic logic [31:0] rom_word(input logic [31:0] idx);
    logic [7:0] b;
    b = idx[7:0];
    return {16'h0000, b ^ 8'hC3, b + 8'h11};
  endfunction

endpackage

// File: rtl/arsp_sync.sv
module arsp_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/arsp_timer.sv
module arsp_timer #(
  parameter int LATENCY = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic done
);

  localparam int CNT_W = $clog2(LATENCY + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= CNT_W'(LATENCY);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/arsp_rom.sv
module arsp_rom
  import arsp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 256,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] word
);

  logic [DATA_W-1:0] table_w [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    localparam logic [31:0] ENTRY = rom_word(32'(g));
    assign table_w[g] = ENTRY[DATA_W-1:0];
  end

  assign word = table_w[idx];

endmodule

// File: rtl/async_read_responder.sv
module async_read_responder
  import arsp_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ROM_DEPTH   = 256,
  parameter int LATENCY     = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              ack_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic              ack_o,
  output logic              ack_oe,
  output logic              drdy_o,
  output logic [DATA_W-1:0] bus_o,
  output logic              bus_oe
);

  localparam int IDX_W = $clog2(ROM_DEPTH);

  // Named internal events, also used by the bound checker
  logic       req_s;
  logic       ack_s;
  logic       timer_done;
  logic       accept;
  logic [1:0] sync_q;

  rsp_state_e        state_q, state_d;
  logic [IDX_W-1:0]  addr_q;
  logic [DATA_W-1:0] rom_q;
  logic              unused_addr_hi;

  arsp_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ack_i, req_i}),
    .q     (sync_q)
  );
  assign req_s = sync_q[0];
  assign ack_s = sync_q[1];

  assign accept = (state_q == RS_IDLE) && req_s;

  arsp_timer #(.LATENCY(LATENCY)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .done  (timer_done)
  );

  arsp_rom #(.DATA_W(DATA_W), .DEPTH(ROM_DEPTH), .IDX_W(IDX_W)) u_rom (
    .idx  (addr_q),
    .word (rom_q)
  );

  assign unused_addr_hi = ^bus_i[DATA_W-1:IDX_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (accept) begin
      addr_q <= bus_i[IDX_W-1:0];
    end
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      RS_IDLE: if (req_s)      state_d = RS_ACK;
      RS_ACK:  if (!req_s)     state_d = RS_WAIT;
      RS_WAIT: if (timer_done) state_d = RS_DATA;
      RS_DATA: if (ack_s)      state_d = RS_DONE;
      RS_DONE: if (!ack_s)     state_d = RS_IDLE;
      default:                 state_d = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RS_IDLE;
    else        state_q <= state_d;
  end

  assign ack_o  = (state_q == RS_ACK);
  assign ack_oe = (state_q == RS_IDLE) || (state_q == RS_ACK) || (state_q == RS_WAIT);
  assign drdy_o = (state_q == RS_DATA);
  assign bus_oe = (state_q == RS_DATA);
  assign bus_o  = bus_oe ? rom_q : '0;

endmodule

// File: rtl/arsp_checker.sv
module arsp_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_s,
  input logic              ack_s,
  input logic              timer_done,
  input logic              ack_o,
  input logic              ack_oe,
  input logic              drdy_o,
  input logic              bus_oe,
  input logic [DATA_W-1:0] bus_o
);

  // R2
  ack_rise_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_o) |-> $past(req_s));

  // R4
  ack_fall_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_o) |-> !$past(req_s));

  // R5
  drdy_after_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drdy_o) |-> $past(timer_done));

  // R6
  data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && $past(bus_oe)) |-> $stable(bus_o));

  // R7
  drdy_fall_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drdy_o) |-> $past(ack_s));

  // R8
  no_ack_drive_in_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> !ack_oe);

  // R9
  accept_after_ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_o) |-> !$past(ack_s));

endmodule

bind async_read_responder arsp_checker #(.DATA_W(DATA_W)) u_arsp_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_s      (req_s),
  .ack_s      (ack_s),
  .timer_done (timer_done),
  .ack_o      (ack_o),
  .ack_oe     (ack_oe),
  .drdy_o     (drdy_o),
  .bus_oe     (bus_oe),
  .bus_o      (bus_o)
);

// File: tb/async_read_responder_tb_top.sv
`timescale 1ns/1ps
module async_read_responder_tb_top;

  localparam int LAT = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_i = 1'b0;
  logic        ack_i = 1'b0;
  logic [15:0] bus_i = '0;
  logic        ack_o, ack_oe, drdy_o, bus_oe;
  logic [15:0] bus_o;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit mon_on = 1'b0;
  int mon_addr = 0;

  async_read_responder #(.DATA_W(16), .ROM_DEPTH(256), .LATENCY(LAT), .SYNC_STAGES(2)) dut_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (req_i),
    .ack_i  (ack_i),
    .bus_i  (bus_i),
    .ack_o  (ack_o),
    .ack_oe (ack_oe),
    .drdy_o (drdy_o),
    .bus_o  (bus_o),
    .bus_oe (bus_oe)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Expected array content, restated arithmetically
  function automatic int ref_word(input int a);
    int b;
    b = a % 256;
    return ((b ^ 195) * 256) + ((b + 17) % 256);
  endfunction

  // Per-clock comparison against the protocol model
  always @(negedge clk) begin
    if (mon_on) begin
      if (drdy_o === 1'b1) begin
        check(bus_oe === 1'b1 && ack_oe === 1'b0, "R8", {bus_oe, ack_oe}, 2);
        check(bus_o == 16'(ref_word(mon_addr)), "R6", bus_o, ref_word(mon_addr));
      end
      if (bus_oe === 1'b0) check(bus_o == 16'h0, "R7", bus_o, 0);
    end
  end

  task automatic start_read(input int addr, output int ta);
    int t0;
    @(negedge clk);
    bus_i = 16'(addr);
    req_i = 1'b1;
    mon_addr = addr;
    t0 = cyc;
    do @(negedge clk); while (ack_o !== 1'b1);
    ta = cyc;
    // R2: third edge after request
    check(ta == t0 + 3, "R2", ta - t0, 3);
  endtask

  task automatic finish_read(input int addr, input int ta, input int hold,
                             input int adly, input bit keep_ack);
    int tr, tw, td, tk, exp_d;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check(ack_o === 1'b1, "R4", ack_o, 1);
    end
    req_i = 1'b0;
    bus_i = ~16'(addr);
    tr = cyc;
    do @(negedge clk); while (ack_o !== 1'b0);
    tw = cyc;
    check(tw == tr + 3, "R4", tw - tr, 3);
    exp_d = (ta + LAT + 1 > tw + 1) ? ta + LAT + 1 : tw + 1;
    do @(negedge clk); while (drdy_o !== 1'b1);
    td = cyc;
    check(td == exp_d, "R5", td, exp_d);
    // R3: captured address survives bus change
    check(bus_o == 16'(ref_word(addr)), "R3", bus_o, ref_word(addr));
    for (int i = 0; i < adly; i++) @(negedge clk);
    ack_i = 1'b1;
    tk = cyc;
    do @(negedge clk); while (drdy_o !== 1'b0);
    check(cyc == tk + 3, "R7", cyc - tk, 3);
    check(bus_oe === 1'b0 && bus_o == 16'h0, "R7", bus_o, 0);
    check(ack_oe === 1'b0, "R8", ack_oe, 0);
    if (!keep_ack) begin
      ack_i = 1'b0;
      repeat (3) @(negedge clk);
      check(ack_oe === 1'b1 && ack_o === 1'b0, "R8", ack_oe, 1);
    end
  endtask

  task automatic full_read(input int addr, input int hold, input int adly);
    int ta;
    start_read(addr, ta);
    finish_read(addr, ta, hold, adly, 1'b0);
  endtask

  initial begin
    #(150000 * 20);
    checks++;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0 (run did not complete)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int ta, tl;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(ack_o === 1'b0 && drdy_o === 1'b0 && bus_oe === 1'b0, "R1",
          {ack_o, drdy_o, bus_oe}, 0);
    check(ack_oe === 1'b1 && bus_o == 16'h0, "R1", ack_oe, 1);
    mon_on = 1'b1;

    // Boundary addresses, short hold: latency dominates (R5)
    full_read(0, 0, 0);
    full_read(255, 1, 2);
    full_read(256, 0, 1);
    full_read(16'hFFFF, 2, 0);
    // Long hold: release dominates (R5)
    full_read(16'h1234, 12, 3);

    // R9: request raised while acknowledge still held
    start_read(16'h00A7, ta);
    finish_read(16'h00A7, ta, 1, 1, 1'b1);
    bus_i = 16'h0042;
    req_i = 1'b1;
    mon_addr = 16'h0042;
    repeat (6) begin
      @(negedge clk);
      check(ack_o === 1'b0, "R9", ack_o, 0);
    end
    ack_i = 1'b0;
    tl = cyc;
    do @(negedge clk); while (ack_o !== 1'b1);
    check(cyc == tl + 4, "R9", cyc - tl, 4);
    finish_read(16'h0042, cyc, 0, 0, 1'b0);

    // Random requester timing
    for (int n = 0; n < 24; n++) begin
      full_read(int'($urandom_range(0, 65535)), int'($urandom_range(0, 9)),
                int'($urandom_range(0, 4)));
    end

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule